// File: doc/BRIEF.md
# Shared-Control Event Counter Bank

This block holds the event counters of a processor core. Three fixed counters are each wired to one dedicated event strobe. A parameterised set of general counters each pick one strobe out of a shared event bus through a select field. Software sees the bank through a flat register port that has an address, a write enable, write data and combinational read data.

Three shared mask registers act on every counter at once. The enable mask switches any mix of counters on or off with one write. The status mask shows every overflow in one read. The clear mask drops any mix of overflow flags with one write. When a counter wraps, its status flag is set. If that counter is allowed to interrupt, the single interrupt line goes high. A debug control bit can also freeze all counting when such an interrupt fires, and the freeze lasts until software writes that bit back to zero. A read-only capability word reports how many fixed counters there are and how wide the counters are.

Register map (6-bit address). 0x00–0x02 are fixed counters 0–2. 0x04 and 0x05 are general counters 0 and 1. 0x08 and 0x09 are the general configurations. 0x10 is the fixed control register. 0x11 is the global enable mask. 0x12 is the global status mask. 0x13 is the overflow clear. 0x14 is debug control. 0x15 is the capability word. In all three masks, bits 2:0 belong to fixed counters 0–2 and bits 4:3 belong to general counters 0–1.

Top module: `evtCounterBank`

## Requirements
- R1: After a synchronous active-low reset, every counter, enable, configuration, status and freeze state is zero and the interrupt is low.
- R2: Fixed counter i increments by one on each clock where its strobe fixedEvt[i] is high, global enable bit i is set, the enable bit (bit 4i) of its 4-bit field in the fixed control register 0x10 is set, and the bank is not frozen.
- R3: General counter g counts gpEvt[sel]. Here sel is bits 6:4 of its configuration register (0x08+g), bit 0 of that register is its local enable, and global enable bit 3+g must also be set.
- R4: A counter that increments from all-ones wraps to zero and sets its bit in the status register 0x12. The bit stays set until it is cleared.
- R5: The interrupt output is high exactly when some status bit is set whose counter has its interrupt-enable bit set. For fixed counter i this is bit 4i+1 of 0x10; for general counter g it is bit 1 of 0x08+g.
- R6: Writing 0x13 clears every status bit where the written data has a one, and 0x13 reads as zero. A clear wins over a wrap that sets the same bit in the same cycle.
- R7: When bit 12 of the debug control register 0x14 is set and a counter with interrupt enable wraps, all counting stops. It stays stopped until a write to 0x14 with bit 12 at zero. A wrap on a counter without interrupt enable does not freeze the bank.
- R8: A counter write stores only the low 16 bits, and the higher bits read as zero. A counter write wins over an increment in the same cycle.
- R9: Register 0x15 is read-only and reads 3 in bits 4:0 and the counter width 16 in bits 12:5, giving 0x203.
- R10: Unmapped addresses read zero and writes to them change nothing. Unimplemented bits of the control registers read zero: 0x10 keeps bits 4i and 4i+1, and 0x08+g keeps bits 0, 1 and 6:4.
- R11: A single write to 0x11 sets the enable state of all five counters at once, and 0x11 reads back the written low five bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Read data for addr (combinational) |
| fixedEvt | input | 3 | Dedicated event strobes of the fixed counters |
| gpEvt | input | 8 | Shared event bus for the general counters |
| irq | output | 1 | Monitoring interrupt (level) |

## Verification
The counters are driven with pseudo-random strobe patterns under several global and local enable masks. This shows whether each of the three gating terms is honoured on its own and whether a general counter follows its selected bus line rather than a neighbour. Some counters are preloaded just below all-ones, which separates a wrap on an interrupt-enabled counter from one without interrupt enable in both the interrupt line and the freeze. A clear written in the same cycle as a wrap, and a counter write in the same cycle as an event, each show which side of that collision wins. A behavioural model predicts the read data and the interrupt on every clock.

// File: rtl/evtPkg.sv
package evtPkg;
  parameter int FIXED_N = 3;
  parameter int GP_N    = 2;
  parameter int CTR_N   = FIXED_N + GP_N;
  parameter int CTR_W   = 16;
  parameter int DATA_W  = 32;
  parameter int ADDR_W  = 6;
  parameter int EVT_N   = 8;
  parameter int SEL_W   = $clog2(EVT_N);

  localparam int A_FIX0   = 'h00;
  localparam int A_GP0    = 'h04;
  localparam int A_GPCFG0 = 'h08;
  localparam int A_FIXCTL = 'h10;
  localparam int A_GLBEN  = 'h11;
  localparam int A_GLBSTS = 'h12;
  localparam int A_OVFCLR = 'h13;
  localparam int A_DBG    = 'h14;
  localparam int A_CAP    = 'h15;

  localparam int FREEZE_BIT = 12;
  localparam int SEL_LSB    = 4;
  localparam logic [DATA_W-1:0] CAP_VALUE =
    DATA_W'(FIXED_N) | (DATA_W'(CTR_W) << 5);

  typedef struct packed {
    logic [CTR_N-1:0] wrSel;
    logic [CTR_N-1:0] countEn;
  } ctrStrobe_t;

  function automatic logic [ADDR_W-1:0] ctrAddr(input int idx);
    if (idx < FIXED_N) return ADDR_W'(A_FIX0 + idx);
    return ADDR_W'(A_GP0 + idx - FIXED_N);
  endfunction

  function automatic logic isMapped(input logic [ADDR_W-1:0] a);
    int v;
    v = int'(a);
    return (v >= A_FIX0 && v < A_FIX0 + FIXED_N) ||
           (v >= A_GP0 && v < A_GP0 + GP_N) ||
           (v >= A_GPCFG0 && v < A_GPCFG0 + GP_N) ||
           (v >= A_FIXCTL && v <= A_CAP);
  endfunction
endpackage

// File: rtl/evtDatapath.sv
module evtDatapath
  import evtPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrStrobe_t              ctrStb,
  input  logic [CTR_W-1:0]        wrValue,
  output logic [CTR_N*CTR_W-1:0]  ctrValue,
  output logic [CTR_N-1:0]        wrapVec
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  for (genvar i = 0; i < CTR_N; i++) begin : g_ctr
    logic [CTR_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rstN)                    cnt <= '0;
      else if (ctrStb.wrSel[i])     cnt <= wrValue;
      else if (ctrStb.countEn[i])   cnt <= cnt + 1'b1;
    end

    assign wrapVec[i] = ctrStb.countEn[i] && !ctrStb.wrSel[i] && (cnt == CTR_MAX);
    assign ctrValue[i*CTR_W +: CTR_W] = cnt;
  end
endmodule

// File: rtl/evtCtrl.sv
module evtCtrl
  import evtPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [FIXED_N-1:0]      fixedEvt,
  input  logic [EVT_N-1:0]        gpEvt,
  input  logic [CTR_N-1:0]        wrapVec,
  input  logic [CTR_N*CTR_W-1:0]  ctrValue,
  output ctrStrobe_t              ctrStb,
  output logic [DATA_W-1:0]       rdData,
  output logic                    irq,
  output logic [CTR_N-1:0]        statusVec,
  output logic                    frozen
);
  logic [FIXED_N-1:0] fixEn, fixIe;
  logic [GP_N-1:0]    gpEn, gpIe;
  logic [SEL_W-1:0]   gpSel [GP_N];
  logic [CTR_N-1:0]   globalEn;
  logic               freezeOnInt;

  logic [CTR_N-1:0]   localEn, ieVec, evtVec, clrMask;
  logic               hitFixCtl, hitGlbEn, hitClr, hitDbg;

  assign hitFixCtl = wrEn && (int'(addr) == A_FIXCTL);
  assign hitGlbEn  = wrEn && (int'(addr) == A_GLBEN);
  assign hitClr    = wrEn && (int'(addr) == A_OVFCLR);
  assign hitDbg    = wrEn && (int'(addr) == A_DBG);

  assign localEn = {gpEn, fixEn};
  assign ieVec   = {gpIe, fixIe};
  assign clrMask = hitClr ? wrData[CTR_N-1:0] : '0;

  assign evtVec[FIXED_N-1:0] = fixedEvt;
  for (genvar g = 0; g < GP_N; g++) begin : g_gpEvt
    assign evtVec[FIXED_N+g] = gpEvt[gpSel[g]];
  end

  for (genvar i = 0; i < CTR_N; i++) begin : g_wrSel
    assign ctrStb.wrSel[i] = wrEn && (addr == ctrAddr(i));
  end
  assign ctrStb.countEn = globalEn & localEn & evtVec & {CTR_N{~frozen}};

  // fixed counter control fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fixEn <= '0;
      fixIe <= '0;
    end else if (hitFixCtl) begin
      for (int i = 0; i < FIXED_N; i++) begin
        fixEn[i] <= wrData[4*i];
        fixIe[i] <= wrData[4*i+1];
      end
    end
  end

  // general counter configuration
  for (genvar g = 0; g < GP_N; g++) begin : g_gpCfg
    logic hitCfg;
    assign hitCfg = wrEn && (int'(addr) == A_GPCFG0 + g);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        gpEn[g]  <= 1'b0;
        gpIe[g]  <= 1'b0;
        gpSel[g] <= '0;
      end else if (hitCfg) begin
        gpEn[g]  <= wrData[0];
        gpIe[g]  <= wrData[1];
        gpSel[g] <= wrData[SEL_LSB +: SEL_W];
      end
    end
  end

  // shared masks, freeze
  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn    <= '0;
      statusVec   <= '0;
      freezeOnInt <= 1'b0;
      frozen      <= 1'b0;
    end else begin
      if (hitGlbEn) globalEn <= wrData[CTR_N-1:0];
      statusVec <= (statusVec | wrapVec) & ~clrMask;
      if (hitDbg) freezeOnInt <= wrData[FREEZE_BIT];
      if (hitDbg && !wrData[FREEZE_BIT])             frozen <= 1'b0;
      else if (freezeOnInt && |(wrapVec & ieVec))    frozen <= 1'b1;
    end
  end

  assign irq = |(statusVec & ieVec);

  // read mux
  always_comb begin
    rdData = '0;
    for (int i = 0; i < CTR_N; i++)
      if (addr == ctrAddr(i)) rdData[CTR_W-1:0] = ctrValue[i*CTR_W +: CTR_W];
    for (int g = 0; g < GP_N; g++)
      if (int'(addr) == A_GPCFG0 + g) begin
        rdData[0] = gpEn[g];
        rdData[1] = gpIe[g];
        rdData[SEL_LSB +: SEL_W] = gpSel[g];
      end
    case (int'(addr))
      A_FIXCTL:
        for (int i = 0; i < FIXED_N; i++) begin
          rdData[4*i]   = fixEn[i];
          rdData[4*i+1] = fixIe[i];
        end
      A_GLBEN:  rdData[CTR_N-1:0] = globalEn;
      A_GLBSTS: rdData[CTR_N-1:0] = statusVec;
      A_DBG:    rdData[FREEZE_BIT] = freezeOnInt;
      A_CAP:    rdData = CAP_VALUE;
      default:  ;
    endcase
  end
endmodule

// File: rtl/evtCounterBank.sv
module evtCounterBank
  import evtPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [FIXED_N-1:0]  fixedEvt,
  input  logic [EVT_N-1:0]    gpEvt,
  output logic                irq
);
  ctrStrobe_t                ctrStb;
  logic [CTR_N*CTR_W-1:0]    ctrValue;
  logic [CTR_N-1:0]          wrapVec;
  logic [CTR_N-1:0]          statusVec;
  logic                      frozen;

  evtCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .fixedEvt(fixedEvt), .gpEvt(gpEvt), .wrapVec(wrapVec), .ctrValue(ctrValue),
    .ctrStb(ctrStb), .rdData(rdData), .irq(irq), .statusVec(statusVec),
    .frozen(frozen)
  );

  evtDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctrStb(ctrStb), .wrValue(wrData[CTR_W-1:0]),
    .ctrValue(ctrValue), .wrapVec(wrapVec)
  );
endmodule

// File: rtl/evtCounterBank_chk.sv
module evtCounterBank_chk
  import evtPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic               irq,
  input logic [CTR_N-1:0]   statusVec,
  input logic [CTR_N-1:0]   wrapVec,
  input logic [CTR_N-1:0]   countEn,
  input logic               frozen
);
  logic clrWr;
  assign clrWr = wrEn && (int'(addr) == A_OVFCLR);

  p_status_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> ((statusVec & $past(statusVec)) == $past(statusVec)));

  p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|wrapVec && !clrWr) |=> ((statusVec & $past(wrapVec)) == $past(wrapVec)));

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((statusVec & $past(wrData[CTR_N-1:0])) == '0));

  p_irq_needs_status_r5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|statusVec));

  p_frozen_no_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    frozen |-> (countEn == '0));

  p_cap_value_r9: assert property (@(posedge clk) disable iff (!rstN)
    (int'(addr) == A_CAP) |-> (rdData == CAP_VALUE));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped(addr) |-> (rdData == '0));
endmodule

bind evtCounterBank evtCounterBank_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .irq(irq), .statusVec(statusVec), .wrapVec(wrapVec),
  .countEn(ctrStb.countEn), .frozen(frozen)
);

// File: tb/evtCounterBank_tb.sv
module evtCounterBank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0]  fixedEvt = '0;
  logic [7:0]  gpEvt = '0;
  logic        irq;

  evtCounterBank u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .fixedEvt(fixedEvt), .gpEvt(gpEvt), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string curReq = "R1";
  logic [2:0]  evF = '0;
  logic [7:0]  evG = '0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference model
  logic [15:0] mCnt [5];
  logic [4:0]  mGEn = '0, mStat = '0;
  logic [2:0]  mFixEn = '0, mFixIe = '0;
  logic [1:0]  mGpEn = '0, mGpIe = '0;
  logic [2:0]  mGpSel [2];
  logic        mFreezeOn = 0, mFrozen = 0;

  function automatic int ctrAddrOf(int i);
    return (i < 3) ? i : 4 + (i - 3);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      for (int i = 0; i < 5; i++) mCnt[i] = '0;
      mGEn = '0; mStat = '0; mFixEn = '0; mFixIe = '0;
      mGpEn = '0; mGpIe = '0; mGpSel[0] = '0; mGpSel[1] = '0;
      mFreezeOn = 0; mFrozen = 0;
    end else begin
      logic [4:0] wrap, lEn, ie, evt;
      wrap = '0;
      lEn = {mGpEn, mFixEn};
      ie  = {mGpIe, mFixIe};
      evt = {gpEvt[mGpSel[1]], gpEvt[mGpSel[0]], fixedEvt};
      for (int i = 0; i < 5; i++) begin
        if (wrEn && int'(addr) == ctrAddrOf(i)) mCnt[i] = wrData[15:0];
        else if (mGEn[i] && lEn[i] && evt[i] && !mFrozen) begin
          if (mCnt[i] == 16'hFFFF) wrap[i] = 1'b1;
          mCnt[i] = mCnt[i] + 16'd1;
        end
      end
      mStat = mStat | wrap;
      if (wrEn && addr == 6'h13) mStat = mStat & ~wrData[4:0];
      if (wrEn && addr == 6'h14 && !wrData[12]) mFrozen = 0;
      else if (mFreezeOn && |(wrap & ie)) mFrozen = 1;
      if (wrEn) begin
        case (addr)
          6'h10: begin
            for (int i = 0; i < 3; i++) begin
              mFixEn[i] = wrData[4*i]; mFixIe[i] = wrData[4*i+1];
            end
          end
          6'h08: begin mGpEn[0] = wrData[0]; mGpIe[0] = wrData[1]; mGpSel[0] = wrData[6:4]; end
          6'h09: begin mGpEn[1] = wrData[0]; mGpIe[1] = wrData[1]; mGpSel[1] = wrData[6:4]; end
          6'h11: mGEn = wrData[4:0];
          6'h14: mFreezeOn = wrData[12];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRd(logic [5:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      6'h00, 6'h01, 6'h02: r = {16'h0, mCnt[a]};
      6'h04: r = {16'h0, mCnt[3]};
      6'h05: r = {16'h0, mCnt[4]};
      6'h08: r = {25'h0, mGpSel[0], 2'b00, mGpIe[0], mGpEn[0]};
      6'h09: r = {25'h0, mGpSel[1], 2'b00, mGpIe[1], mGpEn[1]};
      6'h10: for (int i = 0; i < 3; i++) begin r[4*i] = mFixEn[i]; r[4*i+1] = mFixIe[i]; end
      6'h11: r = {27'h0, mGEn};
      6'h12: r = {27'h0, mStat};
      6'h14: r[12] = mFreezeOn;
      6'h15: r = 32'h0000_0203;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic step(input logic w, input logic [5:0] a, input logic [31:0] d);
    logic [31:0] e;
    logic ei;
    @(negedge clk);
    wrEn = w; addr = a; wrData = d; fixedEvt = evF; gpEvt = evG;
    #1;
    e = expRd(a);
    ei = |(mStat & {mGpIe, mFixIe});
    checks++;
    if (rdData !== e) begin
      fails++;
      $display("FAIL %s rdData addr=%h actual=%h expected=%h", curReq, a, rdData, e);
    end
    checks++;
    if (irq !== ei) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", curReq, irq, ei);
    end
  endtask

  task automatic rd(input logic [5:0] a);
    step(1'b0, a, 32'h0);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    step(1'b1, a, d);
  endtask

  task automatic nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 50000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected=<50000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    curReq = "R1";   // reset state of every register
    for (int a = 0; a < 24; a++) rd(6'(a));

    curReq = "R9";   // capability is read-only
    wr(6'h15, 32'hFFFF_FFFF);
    rd(6'h15);

    curReq = "R10";  // unmapped addresses and reserved bits
    wr(6'h07, 32'hFFFF_FFFF);
    wr(6'h3F, 32'hFFFF_FFFF);
    rd(6'h07); rd(6'h3F); rd(6'h0A); rd(6'h16); rd(6'h03);
    wr(6'h10, 32'hFFFF_FFFF); rd(6'h10);
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08);
    wr(6'h10, 32'h0); wr(6'h08, 32'h0);

    curReq = "R11";  // global mask gating in one write
    wr(6'h10, 32'h111);
    wr(6'h11, 32'h05); rd(6'h11);
    evF = 3'b111;
    for (int k = 0; k < 6; k++) rd(6'(k % 3));
    wr(6'h11, 32'h1F); rd(6'h11);

    curReq = "R2";   // fixed counters, random strobes, local enable off for field 1
    wr(6'h10, 32'h101);
    for (int k = 0; k < 40; k++) begin
      nextRand(); evF = lfsr[2:0];
      rd(6'(k % 3));
    end
    wr(6'h10, 32'h111);
    for (int k = 0; k < 20; k++) begin
      nextRand(); evF = lfsr[4:2];
      rd(6'(k % 3));
    end
    evF = '0;

    curReq = "R3";   // general counters follow selected bus line
    wr(6'h08, 32'h21);
    wr(6'h09, 32'h51);
    for (int k = 0; k < 40; k++) begin
      nextRand(); evG = lfsr[7:0];
      rd((k % 2 == 0) ? 6'h04 : 6'h05);
    end
    wr(6'h08, 32'h71);
    wr(6'h09, 32'h00);
    for (int k = 0; k < 20; k++) begin
      nextRand(); evG = lfsr[9:2];
      rd((k % 2 == 0) ? 6'h04 : 6'h05);
    end
    evG = '0;

    curReq = "R8";   // write truncation and write beats increment
    evF = 3'b001;
    wr(6'h00, 32'hABCD_1234); rd(6'h00); rd(6'h00);
    evG = 8'hFF;
    wr(6'h04, 32'hFFFF_0042); rd(6'h04);
    evF = '0; evG = '0;
    rd(6'h00); rd(6'h04);

    curReq = "R4";   // wrap without interrupt enable
    wr(6'h01, 32'h0000_FFFE);
    evF = 3'b010;
    for (int k = 0; k < 4; k++) rd(6'h12);
    evF = '0;
    rd(6'h01); rd(6'h12);

    curReq = "R5";   // wrap with interrupt enable on field 0
    wr(6'h10, 32'h113);
    wr(6'h00, 32'h0000_FFFD);
    evF = 3'b001;
    for (int k = 0; k < 5; k++) rd(6'h12);
    evF = '0;
    rd(6'h00);

    curReq = "R6";   // clear mask and clear vs wrap collision
    wr(6'h13, 32'h0000_0001); rd(6'h12);
    wr(6'h13, 32'hFFFF_FFFF); rd(6'h12); rd(6'h13);
    wr(6'h00, 32'h0000_FFFF);
    evF = 3'b001;
    wr(6'h13, 32'h0000_0001);
    evF = '0;
    rd(6'h12); rd(6'h00);

    curReq = "R7";   // freeze on interrupt and release
    wr(6'h14, 32'h0000_1000); rd(6'h14);
    wr(6'h01, 32'h0000_FFFF);
    evF = 3'b010;
    for (int k = 0; k < 3; k++) rd(6'h01);
    wr(6'h00, 32'h0000_FFFE);
    evF = 3'b111;
    for (int k = 0; k < 10; k++) rd(6'(k % 3));
    wr(6'h14, 32'h0);
    for (int k = 0; k < 6; k++) rd(6'(k % 3));
    evF = '0;
    wr(6'h13, 32'h1F);
    rd(6'h12);

    finishRun();
  end
endmodule